// File: doc/BRIEF.md
# Byte-Sliced Bidirectional Latched Bus Transceiver

This block connects two 16-bit tri-state buses, the A bus and the B bus, through two independent storage banks: one carries data from A to B and the other from B to A. Every direction is split into two 8-bit byte lanes. Each lane of each direction has its own three active-low controls: a chip enable, a latch enable and an output enable. Tying the matching controls of the two lanes together makes it a single 16-bit transceiver. Leaving them separate makes it two 8-bit transceivers.

Each lane's latch is modelled as a clocked state machine with three states. LANE_OFF is entered by the *park* transition whenever the chip enable is high; the stored byte is frozen. LANE_PASS is entered by the *capture* transition when chip enable and latch enable are both low; the byte on the input bus is copied into the latch at every clock edge. LANE_HOLD is entered by the *seal* transition when chip enable is low and latch enable is high; the stored byte is frozen. A latch-enable rise from LANE_PASS is therefore the moment storage begins. Output drive is separate from the state. A lane puts its latch content onto the far bus, bit by bit through a tri-state assignment, exactly while its chip enable and output enable are both low. Per-lane drive-enable outputs report this. A per-lane contention flag rises when both directions of one lane drive at once.

Top module: `bilatch_xcvr`

## Requirements
- R1: Reset (active-low `rst_n`) clears every latch to 0x00 and places every lane in LANE_OFF. Right after reset, a lane enabled to drive shows 0x00 on its bus.
- R2: While a lane's chip enable is high, its latch keeps its value at every clock edge whatever its latch enable does, and that lane does not drive its output bus even with output enable low.
- R3: While chip enable and latch enable are both low, the lane latch takes the input byte present at each rising clock edge. The driven bus shows that byte from that edge onward.
- R4: While chip enable is low and latch enable is high, the latch keeps its value and ignores changes on the input bus.
- R5: While a lane's output enable is high, that lane of the output bus is released (drive-enable output 0), whatever the chip enable is.
- R6: While chip enable and output enable are both low, the lane drives its latch content onto the output bus and its drive-enable output (`b_drv` for A-to-B, `a_drv` for B-to-A) is 1.
- R7: The B-to-A direction follows R2 to R6, using its own controls, storing bytes from the B bus and driving the A bus.
- R8: Lane 0 covers bits 7:0 and lane 1 covers bits 15:8. Each control input bit [n] acts only on lane n.
- R9: `clash[n]` is 1 exactly when both directions of lane n are enabled to drive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch state machines |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_ab_n | input | 2 | A-to-B chip enable per lane, active low |
| le_ab_n | input | 2 | A-to-B latch enable per lane, active low |
| oe_ab_n | input | 2 | A-to-B output enable per lane, active low |
| ce_ba_n | input | 2 | B-to-A chip enable per lane, active low |
| le_ba_n | input | 2 | B-to-A latch enable per lane, active low |
| oe_ba_n | input | 2 | B-to-A output enable per lane, active low |
| a_io | inout | 16 | A bus: input to A-to-B bank, driven by B-to-A bank |
| b_io | inout | 16 | B bus: input to B-to-A bank, driven by A-to-B bank |
| a_drv | output | 2 | Per-lane flag: block is driving the A bus |
| b_drv | output | 2 | Per-lane flag: block is driving the B bus |
| clash | output | 2 | Per-lane flag: both directions drive at once |

## Verification
A lane stuck in the wrong state, or a latch written when it should hold, shows up as a wrong byte on the far bus. This appears on the first cycle that lane is enabled to drive after the faulty edge. It can stay hidden while the output enable is high, so the stimulus always re-enables drive after each hold step. A wrong lane decode shows at once as a drive-enable bit, or a stored byte, changing in the lane whose controls did not move. A wrong drive gate shows in the same cycle on `a_drv`, `b_drv` and `clash`.

// File: rtl/bilatch_pkg.sv
package bilatch_pkg;

    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_PASS = 2'd1,
        LANE_HOLD = 2'd2
    } lane_state_e;

    function automatic lane_state_e lane_next(input logic ce_n, input logic le_n);
        if (ce_n)      return LANE_OFF;
        else if (le_n) return LANE_HOLD;
        else           return LANE_PASS;
    endfunction

endpackage

// File: rtl/bilatch_lane.sv
module bilatch_lane
    import bilatch_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              le_n,
    input  logic              oe_n,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] q,
    output logic              drive
);

    lane_state_e state_q;
    lane_state_e state_d;

    // next-state selection: park, capture or seal
    always_comb begin
        state_d = lane_next(ce_n, le_n);
    end

    // state register and latch storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LANE_OFF;
            q       <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_d)
                LANE_PASS: q <= din;
                LANE_HOLD: q <= q;
                LANE_OFF:  q <= q;
                default:   q <= q;
            endcase
        end
    end

    // output process: drive gate
    always_comb begin
        drive = !ce_n && !oe_n;
    end

    assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(q));

    assert_pass_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_PASS) |-> (q == $past(din)));

    assert_seal_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && le_n) |=> $stable(q));

endmodule

// File: rtl/bilatch_guard.sv
module bilatch_guard #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] drv_ab,
    input  logic [LANES-1:0] drv_ba,
    output logic [LANES-1:0] clash
);

    always_comb begin
        clash = drv_ab & drv_ba;
    end

endmodule

// File: rtl/bilatch_xcvr.sv
module bilatch_xcvr #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          ce_ab_n,
    input  logic [LANES-1:0]          le_ab_n,
    input  logic [LANES-1:0]          oe_ab_n,
    input  logic [LANES-1:0]          ce_ba_n,
    input  logic [LANES-1:0]          le_ba_n,
    input  logic [LANES-1:0]          oe_ba_n,
    inout  wire  [LANE_W*LANES-1:0]   a_io,
    inout  wire  [LANE_W*LANES-1:0]   b_io,
    output logic [LANES-1:0]          a_drv,
    output logic [LANES-1:0]          b_drv,
    output logic [LANES-1:0]          clash
);

    localparam int BUS_W = LANE_W * LANES;

    logic [BUS_W-1:0] ab_q;
    logic [BUS_W-1:0] ba_q;
    logic [LANES-1:0] ab_drive;
    logic [LANES-1:0] ba_drive;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bilatch_lane #(.LANE_W(LANE_W)) u_ab (
            .clk   (clk),
            .rst_n (rst_n),
            .ce_n  (ce_ab_n[l]),
            .le_n  (le_ab_n[l]),
            .oe_n  (oe_ab_n[l]),
            .din   (a_io[l*LANE_W +: LANE_W]),
            .q     (ab_q[l*LANE_W +: LANE_W]),
            .drive (ab_drive[l])
        );

        bilatch_lane #(.LANE_W(LANE_W)) u_ba (
            .clk   (clk),
            .rst_n (rst_n),
            .ce_n  (ce_ba_n[l]),
            .le_n  (le_ba_n[l]),
            .oe_n  (oe_ba_n[l]),
            .din   (b_io[l*LANE_W +: LANE_W]),
            .q     (ba_q[l*LANE_W +: LANE_W]),
            .drive (ba_drive[l])
        );

        assert_release_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
            oe_ab_n[l] |-> !b_drv[l]);

        assert_release_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
            oe_ba_n[l] |-> !a_drv[l]);

        assert_bus_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
            b_drv[l] |-> (b_io[l*LANE_W +: LANE_W] == ab_q[l*LANE_W +: LANE_W]));

        assert_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_ab_n[l] && !oe_ab_n[l] && !ce_ba_n[l] && !oe_ba_n[l]) |-> clash[l]);
    end

    // per-bit tri-state drive
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        assign b_io[i] = ab_drive[i / LANE_W] ? ab_q[i] : 1'bz;
        assign a_io[i] = ba_drive[i / LANE_W] ? ba_q[i] : 1'bz;
    end

    assign a_drv = ba_drive;
    assign b_drv = ab_drive;

    bilatch_guard #(.LANES(LANES)) u_guard (
        .drv_ab (ab_drive),
        .drv_ba (ba_drive),
        .clash  (clash)
    );

endmodule

// File: tb/sim_bilatch_xcvr.sv
`timescale 1ns/1ps
module sim_bilatch_xcvr;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int BUS_W  = LANE_W * LANES;
    localparam int NV     = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ce_ab_n = '1, le_ab_n = '1, oe_ab_n = '1;
    logic [1:0] ce_ba_n = '1, le_ba_n = '1, oe_ba_n = '1;
    logic [1:0] tb_a_en = '0, tb_b_en = '0;
    logic [BUS_W-1:0] tb_a_val = '0, tb_b_val = '0;
    wire  [BUS_W-1:0] a_bus, b_bus;
    logic [1:0] a_drv, b_drv, clash;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    for (genvar i = 0; i < BUS_W; i++) begin : g_tb
        assign a_bus[i] = tb_a_en[i / LANE_W] ? tb_a_val[i] : 1'bz;
        assign b_bus[i] = tb_b_en[i / LANE_W] ? tb_b_val[i] : 1'bz;
    end

    bilatch_xcvr #(.LANE_W(LANE_W), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
        .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
        .a_io(a_bus), .b_io(b_bus),
        .a_drv(a_drv), .b_drv(b_drv), .clash(clash)
    );

    // stimulus: control bit [n] is lane n
    localparam logic [1:0] V_CEAB [NV] = '{2'b00,2'b00,2'b10,2'b00,2'b00,2'b11,2'b11,2'b11,2'b00,2'b00,2'b11,2'b00};
    localparam logic [1:0] V_LEAB [NV] = '{2'b00,2'b11,2'b00,2'b11,2'b11,2'b11,2'b11,2'b11,2'b11,2'b11,2'b00,2'b11};
    localparam logic [1:0] V_OEAB [NV] = '{2'b11,2'b00,2'b00,2'b00,2'b01,2'b11,2'b11,2'b11,2'b00,2'b10,2'b00,2'b00};
    localparam logic [1:0] V_CEBA [NV] = '{2'b11,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,2'b01,2'b00,2'b00,2'b11,2'b11};
    localparam logic [1:0] V_LEBA [NV] = '{2'b11,2'b11,2'b11,2'b11,2'b11,2'b00,2'b11,2'b00,2'b11,2'b11,2'b11,2'b11};
    localparam logic [1:0] V_OEBA [NV] = '{2'b11,2'b11,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,2'b00,2'b01,2'b11,2'b11};
    localparam logic [1:0] V_AEN  [NV] = '{2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b11,2'b00};
    localparam logic [15:0] V_AVAL [NV] = '{16'h1234,16'hABCD,16'h5566,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0F0F,16'h0000};
    localparam logic [1:0] V_BEN  [NV] = '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b11,2'b11,2'b11,2'b00,2'b00,2'b00,2'b00};
    localparam logic [15:0] V_BVAL [NV] = '{16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h9A7C,16'hFFFF,16'h3344,16'h0000,16'h0000,16'h0000,16'h0000};
    // expected results
    localparam logic [1:0] E_BDRV [NV] = '{2'b00,2'b11,2'b01,2'b11,2'b10,2'b00,2'b00,2'b00,2'b11,2'b01,2'b00,2'b11};
    localparam logic [1:0] E_ADRV [NV] = '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b11,2'b10,2'b11,2'b10,2'b00,2'b00};
    localparam logic [1:0] E_CLSH [NV] = '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b11,2'b00,2'b00,2'b00};
    localparam logic [15:0] E_BVAL [NV] = '{16'h0000,16'h1234,16'h0066,16'h1266,16'h1200,16'h0000,16'h0000,16'h0000,16'h1266,16'h0066,16'h0000,16'h1266};
    localparam logic [15:0] E_AVAL [NV] = '{16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h9A7C,16'h3300,16'h337C,16'h3300,16'h0000,16'h0000};
    localparam string V_REQ [NV] = '{"R3","R4","R8","R2","R5","R7","R7","R8","R9","R9","R2","R2"};

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic apply(input logic [1:0] ceab, leab, oeab, ceba, leba, oeba,
                         input logic [1:0] aen, input logic [15:0] aval,
                         input logic [1:0] ben, input logic [15:0] bval);
        @(negedge clk);
        ce_ab_n = ceab; le_ab_n = leab; oe_ab_n = oeab;
        ce_ba_n = ceba; le_ba_n = leba; oe_ba_n = oeba;
        tb_a_en = aen; tb_a_val = aval; tb_b_en = ben; tb_b_val = bval;
        @(posedge clk);
        #1;
    endtask

    task automatic check_flags(input string req, input logic [1:0] eb, ea, ec);
        check(b_drv == eb, req, {14'd0, b_drv}, {14'd0, eb});
        check(a_drv == ea, req, {14'd0, a_drv}, {14'd0, ea});
        check(clash == ec, req, {14'd0, clash}, {14'd0, ec});
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] m;
        // R1: reset state, all controls inactive
        repeat (3) @(posedge clk);
        #1;
        check_flags("R1", 2'b00, 2'b00, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        // vector table
        for (int k = 0; k < NV; k++) begin
            apply(V_CEAB[k], V_LEAB[k], V_OEAB[k], V_CEBA[k], V_LEBA[k], V_OEBA[k],
                  V_AEN[k], V_AVAL[k], V_BEN[k], V_BVAL[k]);
            check_flags(V_REQ[k], E_BDRV[k], E_ADRV[k], E_CLSH[k]);
            if (E_BDRV[k] != 2'b00) begin
                m = lane_mask(E_BDRV[k]);
                check((b_bus & m) == (E_BVAL[k] & m), V_REQ[k], b_bus & m, E_BVAL[k] & m);
            end
            if (E_ADRV[k] != 2'b00) begin
                m = lane_mask(E_ADRV[k]);
                check((a_bus & m) == (E_AVAL[k] & m), V_REQ[k], a_bus & m, E_AVAL[k] & m);
            end
        end

        // R3: transparent and driving, the bus follows the input at each edge
        apply(2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 16'h1111, 2'b00, 16'h0);
        check(b_bus == 16'h1111, "R3", b_bus, 16'h1111);
        apply(2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 16'h2222, 2'b00, 16'h0);
        check(b_bus == 16'h2222, "R3", b_bus, 16'h2222);
        // R4: latch enable rises, later input changes ignored
        apply(2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 16'h7777, 2'b00, 16'h0);
        check(b_bus == 16'h2222, "R4", b_bus, 16'h2222);

        // R1: reset mid-run clears latches
        @(negedge clk);
        rst_n = 1'b0;
        ce_ab_n = '1; ce_ba_n = '1; oe_ab_n = '1; oe_ba_n = '1;
        tb_a_en = '0; tb_b_en = '0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        apply(2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 16'h0, 2'b00, 16'h0);
        check(b_bus == 16'h0000, "R1", b_bus, 16'h0000);
        apply(2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0, 2'b00, 16'h0);
        check(a_bus == 16'h0000, "R1", a_bus, 16'h0000);
        check_flags("R7", 2'b00, 2'b11, 2'b00);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule